// File: doc/BRIEF.md
# Power-Management Timer with Overflow Event

This block holds a free-running power-management counter and the event registers that report its overflow. A single-cycle tick strobe advances the counter. Its source is a divider from the fixed power-management reference of about 3.58 MHz, and the divider lies outside the block. The counter and all register logic run in the system clock domain. When the counter passes its all-ones value it wraps to zero and sets an overflow status flag. If the matching enable bit is set, an interrupt request is raised. The block fires that interrupt once: the cycle after the request goes high, the whole enable register is cleared. Software must enable it again for the next overflow.

Software reaches the block through a simple register port. A status register sits at offset 0 and an enable register at offset 2, both 16 bits wide. A 32-bit access at offset 0 covers both of them at once. The timer value sits at offset 8 and can only be read. Requests are always accepted: the block has no request-side ready, so a request is taken in every cycle where its strobe is high. A read answers exactly one cycle later with `rd_valid`. The response cannot be held off, so the requester must take the data in that cycle.

Top module: `pmt_timer_top`

## Requirements
- R1: After reset the counter, the status register and the enable register are zero, `irq` is low and `rd_valid` is low.
- R2: On a clock edge with `tick_stb` high the counter increases by one. Without `tick_stb` it holds its value.
- R3: When a tick arrives while the counter is all ones (0xFFFFFF at the default width), the counter becomes zero.
- R4: That wrap sets the overflow status flag, which is bit 0 of the status register. The other status bits always read zero.
- R5: `irq` is high whenever both status bit 0 and enable bit 0 are set. This also applies when the enable bit is written while the status flag is already set.
- R6: On the clock edge after any cycle with `irq` high, the entire 16-bit enable register becomes zero. A software write to the enable register in that same cycle is lost, so `irq` lasts one cycle.
- R7: Status bits are write-one-to-clear: writing 1 to bit 0 clears the flag, and writing 0 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R8: A 16-bit write at offset 2 (`acc_wide`=0) loads all 16 enable bits, and a 16-bit read at offset 2 returns them zero-extended. A 16-bit read at offset 0 returns the status register zero-extended.
- R9: A 32-bit access (`acc_wide`=1) at offset 0 reads as {enable, status}, with status in bits 15:0 and enable in bits 31:16. A 32-bit write there clears status bits by bits 15:0 and loads the enable register from bits 31:16.
- R10: A read at offset 8 returns the counter zero-extended to 32 bits, whatever the access width. Writes to offset 8 change nothing.
- R11: `rd_valid` goes high exactly one cycle after a cycle with `rd_en` high, and is low otherwise. The data reflects the state before that edge. Reads at any other offset, or a 32-bit read at offset 2, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_stb | input | 1 | One-cycle strobe at the timer rate; advances the counter |
| rd_en | input | 1 | Read request strobe |
| wr_en | input | 1 | Write request strobe |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| addr | input | ADDR_W (4) | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Overflow interrupt request level |

## Verification
The counter is first run with sparse ticks and with back-to-back ticks, which shows whether it advances only on strobes. Wraps are then driven with the enable bit clear and with it set: the first must leave `irq` low, and the second must give a one-cycle pulse and an enable register of zero. Status clears are tried with a zero mask, with a one mask, and in the same cycle as a wrap, which tells write-one-to-clear apart from plain writes and checks that set wins over clear. The bench also tries 16-bit versus 32-bit accesses, writes to the timer and unmapped offsets, which shows the two register halves are placed correctly and that the timer cannot be written.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned OVF_BIT = 0;
  localparam int unsigned OFS_STS = 0;
  localparam int unsigned OFS_EN  = 2;
  localparam int unsigned OFS_TMR = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_EVT,
    SEL_TMR
  } rd_sel_e;
endpackage

// File: rtl/pmt_tick_counter.sv
module pmt_tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_stb,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  assign wrap_o  = tick_stb && (count_q == CNT_MAX);
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick_stb) begin
      if (wrap_o) count_q <= '0;
      else        count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmt_event_regs.sv
module pmt_event_regs #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned OVF_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_i,
  input  logic [REG_W-1:0] sts_clr_i,
  input  logic             en_we_i,
  input  logic [REG_W-1:0] en_wdata_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic             irq_o
);
  logic [REG_W-1:0] en_q;

  for (genvar i = 0; i < REG_W; i++) begin : g_sts
    if (i == OVF_BIT) begin : g_ovf
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           flag_q <= 1'b0;
        else if (wrap_i)      flag_q <= 1'b1;
        else if (sts_clr_i[i]) flag_q <= 1'b0;
      end
      assign sts_o[i] = flag_q;
    end else begin : g_none
      assign sts_o[i] = 1'b0;
    end
  end

  assign irq_o = sts_o[OVF_BIT] && en_q[OVF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (irq_o)   en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/pmt_read_mux.sv
module pmt_read_mux
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  rd_sel_e          sel_i,
  input  logic [REG_W-1:0] sts_i,
  input  logic [REG_W-1:0] en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             rd_valid_o,
  output logic [BUS_W-1:0] rd_data_o
);
  logic [BUS_W-1:0] rd_val;

  always_comb begin
    unique case (sel_i)
      SEL_STS: rd_val = BUS_W'(sts_i);
      SEL_EN:  rd_val = BUS_W'(en_i);
      SEL_EVT: rd_val = {en_i, sts_i};
      SEL_TMR: rd_val = BUS_W'(count_i);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_val;
    end
  end
endmodule

// File: rtl/pmt_timer_top.sv
module pmt_timer_top
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_stb,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              acc_wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TMR);

  logic [CNT_W-1:0] tmr_count;
  logic             tmr_wrap;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] sts_clr;
  logic             en_we;
  logic [REG_W-1:0] en_wdata;
  rd_sel_e          sel;

  always_comb begin
    if (addr == A_TMR)                  sel = SEL_TMR;
    else if (addr == A_STS)             sel = acc_wide ? SEL_EVT : SEL_STS;
    else if (addr == A_EN && !acc_wide) sel = SEL_EN;
    else                                sel = SEL_NONE;
  end

  assign sts_clr  = (wr_en && (sel == SEL_STS || sel == SEL_EVT)) ? wr_data[REG_W-1:0] : '0;
  assign en_we    = wr_en && (sel == SEL_EN || sel == SEL_EVT);
  assign en_wdata = (sel == SEL_EVT) ? wr_data[2*REG_W-1:REG_W] : wr_data[REG_W-1:0];

  pmt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_stb (tick_stb),
    .count_o  (tmr_count),
    .wrap_o   (tmr_wrap)
  );

  pmt_event_regs #(.REG_W(REG_W), .OVF_BIT(OVF_BIT)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap_i     (tmr_wrap),
    .sts_clr_i  (sts_clr),
    .en_we_i    (en_we),
    .en_wdata_i (en_wdata),
    .sts_o      (sts_q),
    .en_o       (en_q),
    .irq_o      (irq)
  );

  pmt_read_mux #(.CNT_W(CNT_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en),
    .sel_i      (sel),
    .sts_i      (sts_q),
    .en_i       (en_q),
    .count_i    (tmr_count),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );
endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_stb,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [REG_W-1:0] sts_q,
  input logic [REG_W-1:0] en_q
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_stb |=> $stable(count));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_stb && count == CMAX) |=> (count == '0));

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_stb && count == CMAX) |=> sts_q[OVF_BIT]);

  // R5
  irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_stb && count == CMAX && en_q[OVF_BIT] && !irq && !wr_en) |=> irq);

  // R6
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (en_q == '0));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[OVF_BIT] && !wr_en) |=> sts_q[OVF_BIT]);

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind pmt_timer_top pmt_timer_chk #(.CNT_W(CNT_W)) u_pmt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_stb (tick_stb),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .irq      (irq),
  .count    (tmr_count),
  .sts_q    (sts_q),
  .en_q     (en_q)
);

// File: tb/pmt_timer_top_bench.sv
`timescale 1ns/1ps
module pmt_timer_top_bench;
  localparam int CW = 8;
  localparam int AW = 4;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_stb = 1'b0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          acc_wide = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          irq;

  always #2.5 clk = ~clk;

  pmt_timer_top #(.CNT_W(CW), .ADDR_W(AW)) u_pmt_timer_top (
    .clk(clk), .rst_n(rst_n), .tick_stb(tick_stb), .rd_en(rd_en), .wr_en(wr_en),
    .acc_wide(acc_wide), .addr(addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  int        n_vec = 0;
  int        n_bad = 0;
  int        cycles = 0;
  string     cur_req = "R1";
  int        m_cnt;
  bit [15:0] m_sts;
  bit [15:0] m_en;
  bit        m_rdv;
  bit [31:0] m_rdd;
  bit        m_wrap;
  bit        m_irq;
  bit        done = 1'b0;

  function automatic bit [31:0] model_read(input int a, input bit wide);
    if (a == 8) return 32'(m_cnt);
    if (a == 0) return wide ? {m_en, m_sts} : {16'h0, m_sts};
    if (a == 2 && !wide) return {16'h0, m_en};
    return 32'h0;
  endfunction

  // Behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sts = '0; m_en = '0; m_rdv = 1'b0; m_rdd = '0;
    end else begin
      m_irq = m_sts[0] && m_en[0];
      m_rdv = rd_en;
      if (rd_en) m_rdd = model_read(int'(addr), acc_wide);
      m_wrap = tick_stb && (m_cnt == MAXV);
      if (tick_stb) m_cnt = m_wrap ? 0 : m_cnt + 1;
      if (wr_en && addr == 0 && wr_data[0]) m_sts[0] = 1'b0;
      if (m_wrap) m_sts[0] = 1'b1;
      if (m_irq) m_en = '0;
      else if (wr_en && addr == 0 && acc_wide) m_en = wr_data[31:16];
      else if (wr_en && addr == 2 && !acc_wide) m_en = wr_data[15:0];
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      n_vec++;
      if (irq !== (m_sts[0] && m_en[0])) begin
        n_bad++;
        $display("FAIL R5 irq: actual %0b expected %0b", irq, m_sts[0] && m_en[0]);
      end
      n_vec++;
      if (rd_valid !== m_rdv) begin
        n_bad++;
        $display("FAIL R11 rd_valid: actual %0b expected %0b", rd_valid, m_rdv);
      end
      if (m_rdv) begin
        n_vec++;
        if (rd_data !== m_rdd) begin
          n_bad++;
          $display("FAIL %s rd_data: actual %08h expected %08h", cur_req, rd_data, m_rdd);
        end
      end
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  task automatic step(input bit t, input bit re, input bit we, input bit wide,
                      input int a, input bit [31:0] d);
    tick_stb = t; rd_en = re; wr_en = we; acc_wide = wide;
    addr = AW'(a); wr_data = d;
    @(negedge clk);
    tick_stb = 1'b0; rd_en = 1'b0; wr_en = 1'b0; acc_wide = 1'b0;
  endtask

  task automatic rd(input int a, input bit wide);
    step(1'b0, 1'b1, 1'b0, wide, a, 32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h0);
  endtask

  task automatic wr(input int a, input bit wide, input bit [31:0] d);
    step(1'b0, 1'b0, 1'b1, wide, a, d);
  endtask

  task automatic run_to(input int v);
    while (m_cnt != v) step(1'b1, 1'b0, 1'b0, 1'b0, 0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents
    cur_req = "R1";
    rd(0, 1'b1); rd(8, 1'b0); rd(2, 1'b0);

    // R2: sparse and back-to-back ticks
    cur_req = "R2";
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
      step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    end
    rd(8, 1'b0);
    repeat (7) step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    rd(8, 1'b1);

    // R8: narrow enable write and read-back
    cur_req = "R8";
    wr(2, 1'b0, 32'hFFFF_A5A4);
    rd(2, 1'b0); rd(0, 1'b0);

    // R9: wide event write and read
    cur_req = "R9";
    wr(0, 1'b1, 32'h1234_0000);
    rd(0, 1'b1); rd(2, 1'b0);

    // R10: timer writes ignored
    cur_req = "R10";
    wr(8, 1'b1, 32'hDEAD_BEEF);
    wr(8, 1'b0, 32'h0000_0055);
    rd(8, 1'b1);

    // R11: unmapped offsets and wide read at offset 2
    cur_req = "R11";
    rd(4, 1'b1); rd(2, 1'b1); rd(14, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 0, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);

    // R3 / R4: wrap with overflow disabled
    cur_req = "R3";
    wr(2, 1'b0, 32'h0);
    run_to(MAXV);
    rd(8, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    rd(8, 1'b0);
    cur_req = "R4";
    rd(0, 1'b0);

    // R7: zero mask keeps, one mask clears
    cur_req = "R7";
    wr(0, 1'b0, 32'h0000_FFFE);
    rd(0, 1'b0);
    wr(0, 1'b0, 32'h0000_0001);
    rd(0, 1'b0);

    // R5 / R6: enabled wrap gives a single pulse and clears enable
    cur_req = "R6";
    wr(2, 1'b0, 32'h0000_8001);
    run_to(MAXV);
    step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 2, 32'h0000_0003);
    rd(2, 1'b0); rd(0, 1'b1);

    // R5: enabling while status already set
    cur_req = "R5";
    wr(0, 1'b1, 32'h0001_0000);
    rd(0, 1'b1);

    // R7: wrap and clear in the same cycle, set wins
    cur_req = "R7";
    wr(0, 1'b0, 32'h1);
    run_to(MAXV);
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, 32'h1);
    rd(0, 1'b0);
    wr(0, 1'b1, 32'h0000_0001);
    rd(0, 1'b1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule